// File: doc/BRIEF.md
# Breakpoint Trap Entry Sequencer

This block carries out trap entry for the processor's one-byte breakpoint opcode. When the decode stage presents a valid opcode byte of all ones, the sequencer takes a snapshot of the current program counter, status word and system stack pointer. It moves the stack pointer down by one six-byte frame and writes three 16-bit words to that frame through a word-wide data memory write port. It then reads a new status word and a new program counter from a fixed vector table through a code memory read port.

The opcode byte that unprogrammed memory returns is the breakpoint itself, and the all-zeros byte is a no-operation. An erased code byte therefore leads either to a trap or to nothing. The trap entry lasts a fixed number of clocks. A mode input, sampled when the trigger is accepted, selects the count: 23 clocks for the normal memory mode and 19 clocks for the page-zero mode. A one-cycle done strobe marks the last clock. The new program counter has its upper byte and its lowest bit cleared. All status flags come only from the vector table.

Top module: `bkpt_trap_seq`

## Requirements
- R1: A trap starts only on a clock edge where `op_valid` is 1 and `op_byte` equals 8'hFF. The opcode 8'h00, any other byte, or 8'hFF with `op_valid` at 0 leaves `busy` at 0 and causes no memory access.
- R2: From the cycle after acceptance, `ssp_out` equals `ssp_in` minus 6, taken modulo 2^16, where `ssp_in` is sampled at acceptance.
- R3: Cycle 1 is the cycle that begins at the acceptance edge. In cycles 2, 3 and 4, `dmem_we` is 1 and the block writes three 16-bit words, one per cycle, in this order:
  - the low 16 bits of the incremented PC, at the new SSP;
  - the upper PC byte, zero-extended, at SSP+2;
  - the saved status word, at SSP+4.
  In every other cycle `dmem_we` is 0.
- R4: In cycle 5, `cmem_re` is 1 and `cmem_addr` is the vector base. In cycle 6, `cmem_re` is 1 and `cmem_addr` is the vector base plus 2. In every other cycle `cmem_re` is 0.
- R5: From cycle 6 on, `psw_out` equals the word read at the vector base, bit for bit. No flag is altered by the trap.
- R6: From cycle 7 on, `pc_out` equals the word read at vector base plus 2, with bit 0 forced to 0 and bits 23:16 forced to 0.
- R7: `done` is high for exactly one cycle. That cycle is cycle 23 when `page_zero` was 0 at acceptance, and cycle 19 when it was 1.
- R8: `busy` is high from cycle 1 through the done cycle. A trigger that arrives while `busy` is high is ignored and alters no saved value.
- R9: While `rst` is high at a clock edge, the sequencer returns to idle. After that edge, `busy`, `done`, `dmem_we` and `cmem_re` are 0 and `pc_out`, `psw_out` and `ssp_out` are 0.
- R10: The saved PC is `pc_in` plus 1, taken modulo 2^24. So 24'hFFFFFF is saved as 0 in both the low word and the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Decode presents an opcode byte this cycle |
| op_byte | input | 8 | Opcode byte from decode |
| page_zero | input | 1 | 1 selects the page-zero memory mode (shorter sequence) |
| pc_in | input | 24 | Program counter addressing the breakpoint opcode |
| psw_in | input | 16 | Current status word |
| ssp_in | input | 16 | Current system stack pointer |
| dmem_we | output | 1 | Word write strobe to data memory |
| dmem_addr | output | 16 | Byte address of the word being written |
| dmem_wdata | output | 16 | Word being written |
| cmem_re | output | 1 | Code memory read strobe |
| cmem_addr | output | 24 | Code memory byte address |
| cmem_rdata | input | 16 | Code memory read word, valid in the same cycle as its address |
| pc_out | output | 24 | New program counter |
| psw_out | output | 16 | New status word |
| ssp_out | output | 16 | Lowered stack pointer |
| busy | output | 1 | Trap entry in progress |
| done | output | 1 | One-cycle strobe on the last cycle of trap entry |

## Verification
The trap is started with the normal and the page-zero mode. These runs separate the two cycle counts and show that the mode is latched at acceptance. Opcodes 00h, 5Ah and a non-valid FFh show that only a valid all-ones byte starts the sequence. A program counter of all ones together with a stack pointer near zero exposes missing wrap-around in the increment and the frame arithmetic. An odd vector word separates a correctly cleared bit 0 from a plain copy. Further runs place a second trigger inside a sequence, hold the trigger across the done cycle, and reset in the middle of the sequence. These show that a sequence in flight cannot be restarted and that a reset leaves the memory ports quiet.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int PC_W        = 24;
  localparam int WORD_W      = 16;
  localparam int OP_W        = 8;
  localparam int FRAME_WORDS = 3;
  localparam int FRAME_BYTES = 2 * FRAME_WORDS;
  localparam int VEC_WORDS   = 2;
  // step numbers counted from 0 in the first busy cycle
  localparam int STEP_WR0    = 1;
  localparam int STEP_RD0    = STEP_WR0 + FRAME_WORDS;
  localparam int MIN_CYCLES  = STEP_RD0 + VEC_WORDS + 1;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [WORD_W-1:0] word_t;

  // return address: one byte past the opcode, wrapping at 24 bits
  function automatic pc_t pc_after_op(pc_t pc);
    return pc + pc_t'(1);
  endfunction

  function automatic word_t ssp_lower(word_t s);
    return s - word_t'(FRAME_BYTES);
  endfunction

  function automatic word_t slot_addr(word_t base, int unsigned idx);
    return base + word_t'(2 * idx);
  endfunction

  // frame word contents by slot index
  function automatic word_t frame_word(pc_t pc, word_t psw, int unsigned idx);
    word_t w;
    case (idx)
      0:       w = pc[WORD_W-1:0];
      1:       w = word_t'(pc[PC_W-1:WORD_W]);
      default: w = psw;
    endcase
    return w;
  endfunction

  // new PC: upper byte cleared, lowest bit cleared
  function automatic pc_t pc_from_vector(word_t w);
    pc_t r;
    r = '0;
    r[WORD_W-1:1] = w[WORD_W-1:1];
    return r;
  endfunction
endpackage

// File: rtl/bkpt_trig_decode.sv
module bkpt_trig_decode #(
  parameter int OP_W = bkpt_pkg::OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_byte,
  input  logic            busy,
  output logic            op_is_bkpt,
  output logic            accept
);
  localparam logic [OP_W-1:0] BKPT_CODE = '1;

  assign op_is_bkpt = op_valid && (op_byte == BKPT_CODE);
  assign accept     = op_is_bkpt && !busy;

  // R1: the all-zeros opcode never starts a trap
  p_nop_no_trap_r1: assert property (@(posedge clk) disable iff (rst)
    (op_byte == '0) |-> !accept);

  // R8: nothing is accepted while a sequence runs
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);
endmodule

// File: rtl/bkpt_step_ctr.sv
module bkpt_step_ctr #(
  parameter int CYC_NORM = 23,
  parameter int CYC_PZ   = 19,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pz_mode,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST_NORM = CNT_W'(CYC_NORM - 1);
  localparam logic [CNT_W-1:0] LAST_PZ   = CNT_W'(CYC_PZ - 1);

  logic [CNT_W-1:0] last_q;

  assign done = busy && (cnt == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      last_q <= '0;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      last_q <= pz_mode ? LAST_PZ : LAST_NORM;
    end
  end

  // R7: the counter never runs past the selected end
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= last_q));

  // R7: done is followed by idle
  p_done_ends_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R8: a running sequence keeps stepping, a late start changes nothing
  p_step_on_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/bkpt_frame_port.sv
module bkpt_frame_port
  import bkpt_pkg::*;
#(
  parameter int        CNT_W    = 5,
  parameter logic [23:0] VEC_BASE = 24'h002018
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  word_t            ssp_base,
  input  pc_t              pc_saved,
  input  word_t            psw_saved,
  output logic             dmem_we,
  output word_t            dmem_addr,
  output word_t            dmem_wdata,
  output logic             cmem_re,
  output pc_t              cmem_addr,
  output logic             ld_psw,
  output logic             ld_pc
);
  logic  [FRAME_WORDS-1:0] slot_hit;
  word_t                   slot_a [FRAME_WORDS];
  word_t                   slot_d [FRAME_WORDS];
  logic  [VEC_WORDS-1:0]   rd_hit;
  pc_t                     rd_a   [VEC_WORDS];

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
    assign slot_hit[g] = busy && (cnt == CNT_W'(STEP_WR0 + g));
    assign slot_a[g]   = slot_addr(ssp_base, g);
    assign slot_d[g]   = frame_word(pc_saved, psw_saved, g);
    if (g > 0) begin : g_order
      // R3: frame words go out on consecutive cycles in slot order
      p_slot_order_r3: assert property (@(posedge clk) disable iff (rst)
        slot_hit[g-1] |=> slot_hit[g]);
    end
  end

  for (genvar v = 0; v < VEC_WORDS; v++) begin : g_vec
    assign rd_hit[v] = busy && (cnt == CNT_W'(STEP_RD0 + v));
    assign rd_a[v]   = VEC_BASE + pc_t'(2 * v);
  end

  always_comb begin
    dmem_we    = |slot_hit;
    dmem_addr  = '0;
    dmem_wdata = '0;
    for (int i = 0; i < FRAME_WORDS; i++) begin
      if (slot_hit[i]) begin
        dmem_addr  = slot_a[i];
        dmem_wdata = slot_d[i];
      end
    end
  end

  always_comb begin
    cmem_re   = |rd_hit;
    cmem_addr = '0;
    for (int i = 0; i < VEC_WORDS; i++) begin
      if (rd_hit[i]) cmem_addr = rd_a[i];
    end
  end

  assign ld_psw = rd_hit[0];
  assign ld_pc  = rd_hit[VEC_WORDS-1];

  // R3 / R4: at most one memory step per cycle
  p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({slot_hit, rd_hit}));

  // R4: the status word is read before the PC word
  p_psw_first_r4: assert property (@(posedge clk) disable iff (rst)
    ld_psw |=> ld_pc);

  // R4: reads begin right after the last frame write
  p_read_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    slot_hit[FRAME_WORDS-1] |=> ld_psw);
endmodule

// File: rtl/bkpt_trap_seq.sv
module bkpt_trap_seq
  import bkpt_pkg::*;
#(
  parameter int          CYC_NORM = 23,
  parameter int          CYC_PZ   = 19,
  parameter logic [23:0] VEC_BASE = 24'h002018
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        op_valid,
  input  logic [7:0]  op_byte,
  input  logic        page_zero,
  input  logic [23:0] pc_in,
  input  logic [15:0] psw_in,
  input  logic [15:0] ssp_in,
  output logic        dmem_we,
  output logic [15:0] dmem_addr,
  output logic [15:0] dmem_wdata,
  output logic        cmem_re,
  output logic [23:0] cmem_addr,
  input  logic [15:0] cmem_rdata,
  output logic [23:0] pc_out,
  output logic [15:0] psw_out,
  output logic [15:0] ssp_out,
  output logic        busy,
  output logic        done
);
  localparam int CYC_MAX = (CYC_NORM > CYC_PZ) ? CYC_NORM : CYC_PZ;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);

  // named internal events
  logic             accept;
  logic             op_is_bkpt;
  logic [CNT_W-1:0] step;
  logic             ld_psw;
  logic             ld_pc;

  pc_t   pc_saved_q;
  word_t psw_saved_q;
  word_t ssp_q;
  word_t psw_new_q;
  pc_t   pc_new_q;

  bkpt_trig_decode #(.OP_W(OP_W)) u_decode (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_byte    (op_byte),
    .busy       (busy),
    .op_is_bkpt (op_is_bkpt),
    .accept     (accept)
  );

  bkpt_step_ctr #(
    .CYC_NORM (CYC_NORM),
    .CYC_PZ   (CYC_PZ),
    .CNT_W    (CNT_W)
  ) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .pz_mode (page_zero),
    .busy    (busy),
    .cnt     (step),
    .done    (done)
  );

  bkpt_frame_port #(
    .CNT_W    (CNT_W),
    .VEC_BASE (VEC_BASE)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cnt        (step),
    .ssp_base   (ssp_q),
    .pc_saved   (pc_saved_q),
    .psw_saved  (psw_saved_q),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .cmem_re    (cmem_re),
    .cmem_addr  (cmem_addr),
    .ld_psw     (ld_psw),
    .ld_pc      (ld_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_saved_q  <= '0;
      psw_saved_q <= '0;
      ssp_q       <= '0;
      psw_new_q   <= '0;
      pc_new_q    <= '0;
    end else begin
      if (accept) begin
        pc_saved_q  <= pc_after_op(pc_in);
        psw_saved_q <= psw_in;
        ssp_q       <= ssp_lower(ssp_in);
      end
      if (ld_psw) psw_new_q <= cmem_rdata;
      if (ld_pc)  pc_new_q  <= pc_from_vector(cmem_rdata);
    end
  end

  assign pc_out  = pc_new_q;
  assign psw_out = psw_new_q;
  assign ssp_out = ssp_q;

  // R2: the stack pointer drops by one frame at acceptance
  p_ssp_drop_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (ssp_out == $past(ssp_in) - 16'd6));

  // R5: the status word is an exact copy of the vector word
  p_psw_copy_r5: assert property (@(posedge clk) disable iff (rst)
    ld_psw |=> (psw_out == $past(cmem_rdata)));

  // R6: the new PC is even and lies in the low 64 KiB
  p_pc_shape_r6: assert property (@(posedge clk) disable iff (rst)
    ld_pc |=> (pc_out[0] == 1'b0 && pc_out[23:16] == 8'h00));

  // R7: done lasts one cycle
  p_done_once_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: memory ports stay quiet while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!dmem_we && !cmem_re));

  // R9: reset leaves the sequencer idle
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (!busy && !done));

  // R1: a start always needs the breakpoint opcode
  p_start_needs_op_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(op_is_bkpt));
endmodule

// File: tb/bkpt_trap_seq_test.sv
module bkpt_trap_seq_test;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [23:0] VEC        = 24'h002018;
  localparam int          N_NORM     = 23;
  localparam int          N_PZ       = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic        page_zero = 1'b0;
  logic [23:0] pc_in = '0;
  logic [15:0] psw_in = '0;
  logic [15:0] ssp_in = '0;
  logic        dmem_we;
  logic [15:0] dmem_addr, dmem_wdata;
  logic        cmem_re;
  logic [23:0] cmem_addr;
  logic [15:0] cmem_rdata;
  logic [23:0] pc_out;
  logic [15:0] psw_out, ssp_out;
  logic        busy, done;

  logic [15:0] vec_psw = 16'h0F0F;
  logic [15:0] vec_pc  = 16'h3457;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit started = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // code memory: asynchronous read of the two vector words
  assign cmem_rdata = (cmem_addr == VEC)          ? vec_psw :
                      (cmem_addr == VEC + 24'd2)  ? vec_pc  : 16'hDEAD;

  bkpt_trap_seq uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
    .page_zero(page_zero), .pc_in(pc_in), .psw_in(psw_in), .ssp_in(ssp_in),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .cmem_re(cmem_re), .cmem_addr(cmem_addr), .cmem_rdata(cmem_rdata),
    .pc_out(pc_out), .psw_out(psw_out), .ssp_out(ssp_out),
    .busy(busy), .done(done)
  );

  // behavioural reference: step index since acceptance
  bit          m_busy;
  int          m_cnt, m_len;
  logic [23:0] m_ret;
  logic [15:0] m_ssp, m_psw_keep, m_psw_new;
  logic [23:0] m_pc_new;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_len = 0;
      m_ret = 0; m_ssp = 0; m_psw_keep = 0; m_psw_new = 0; m_pc_new = 0;
    end else if (m_busy) begin
      if (m_cnt == 4) m_psw_new = vec_psw;
      if (m_cnt == 5) m_pc_new = {8'h00, vec_pc & 16'hFFFE};
      if (m_cnt == m_len - 1) begin m_busy = 0; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end else if (op_valid && op_byte == 8'hFF) begin
      m_busy = 1; m_cnt = 0;
      m_len = page_zero ? N_PZ : N_NORM;
      m_ret = pc_in + 24'd1;
      m_ssp = ssp_in - 16'd6;
      m_psw_keep = psw_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference on every clock, away from the edge
  always @(negedge clk) begin
    if (started && !finished) begin
      logic        e_we, e_re;
      logic [15:0] e_a, e_d;
      logic [23:0] e_ca;
      e_we = m_busy && m_cnt >= 1 && m_cnt <= 3;
      e_re = m_busy && (m_cnt == 4 || m_cnt == 5);
      e_a  = m_ssp + 16'(2 * (m_cnt - 1));
      e_d  = (m_cnt == 1) ? m_ret[15:0] :
             (m_cnt == 2) ? {8'h00, m_ret[23:16]} : m_psw_keep;
      e_ca = VEC + 24'(2 * (m_cnt - 4));
      chk("R8 busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R7 done", {31'd0, done}, {31'd0, m_busy && m_cnt == m_len - 1});
      chk("R3 dmem_we", {31'd0, dmem_we}, {31'd0, e_we});
      if (e_we) begin
        chk("R3 dmem_addr", {16'd0, dmem_addr}, {16'd0, e_a});
        chk("R3/R10 dmem_wdata", {16'd0, dmem_wdata}, {16'd0, e_d});
      end
      chk("R4 cmem_re", {31'd0, cmem_re}, {31'd0, e_re});
      if (e_re) chk("R4 cmem_addr", {8'd0, cmem_addr}, {8'd0, e_ca});
      chk("R2 ssp_out", {16'd0, ssp_out}, {16'd0, m_ssp});
      chk("R5 psw_out", {16'd0, psw_out}, {16'd0, m_psw_new});
      chk("R6 pc_out", {8'd0, pc_out}, {8'd0, m_pc_new});
    end
  end

  // present one opcode for one cycle; returns in cycle 1 of a trap
  task automatic present(input logic [7:0] op, input logic v, input logic pz,
                         input logic [23:0] pc, input logic [15:0] psw,
                         input logic [15:0] ssp);
    @(negedge clk);
    op_valid = v; op_byte = op; page_zero = pz;
    pc_in = pc; psw_in = psw; ssp_in = ssp;
    @(negedge clk);
    op_valid = 0; op_byte = 8'h00;
  endtask

  // count cycles until done; cycle 1 is the current one
  task automatic wait_done(input int exp_len, input string tag);
    int k = 1;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(tag, k, exp_len);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: reset state
    chk("R9 reset busy", {31'd0, busy}, 0);
    chk("R9 reset dmem_we", {31'd0, dmem_we}, 0);
    chk("R9 reset pc_out", {8'd0, pc_out}, 0);

    // R1: no-operation, other byte, and not-valid all-ones
    present(8'h00, 1, 0, 24'h000100, 16'h1111, 16'h4000);
    chk("R1 nop no trap", {31'd0, busy}, 0);
    present(8'h5A, 1, 0, 24'h000100, 16'h1111, 16'h4000);
    chk("R1 other byte no trap", {31'd0, busy}, 0);
    present(8'hFF, 0, 0, 24'h000100, 16'h1111, 16'h4000);
    chk("R1 invalid no trap", {31'd0, busy}, 0);
    chk("R1 ssp untouched", {16'd0, ssp_out}, 0);

    // normal mode
    present(8'hFF, 1, 0, 24'h123456, 16'hA5C3, 16'h8000);
    wait_done(N_NORM, "R7 normal length");
    chk("R5 psw loaded", {16'd0, psw_out}, 32'h0F0F);
    chk("R6 pc loaded", {8'd0, pc_out}, 32'h003456);
    chk("R2 ssp lowered", {16'd0, ssp_out}, 32'h7FFA);

    // page-zero mode with other vector words
    vec_psw = 16'hFFFF; vec_pc = 16'hFFFF;
    present(8'hFF, 1, 1, 24'h00ABCD, 16'h0001, 16'h1000);
    wait_done(N_PZ, "R7 page-zero length");
    chk("R6 pc forced bits", {8'd0, pc_out}, 32'h00FFFE);

    // R10: PC and stack wrap
    vec_psw = 16'h8001; vec_pc = 16'h0002;
    present(8'hFF, 1, 0, 24'hFFFFFF, 16'h7E7E, 16'h0004);
    @(negedge clk);
    chk("R10 wrapped low word", {16'd0, dmem_wdata}, 0);
    chk("R2 ssp wraps", {16'd0, ssp_out}, 32'hFFFE);
    wait_done(N_NORM - 1, "R7 wrap run length");

    // R8: second trigger in flight is ignored
    present(8'hFF, 1, 1, 24'h000010, 16'h2222, 16'h3000);
    @(negedge clk);
    op_valid = 1; op_byte = 8'hFF; page_zero = 0; ssp_in = 16'h9000;
    @(negedge clk);
    op_valid = 0;
    wait_done(N_PZ - 2, "R8 late trigger no restart");
    chk("R8 ssp kept", {16'd0, ssp_out}, 32'h2FFA);

    // R9: reset in the middle, then a clean trap
    present(8'hFF, 1, 0, 24'h000200, 16'h3333, 16'h5000);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R9 mid reset busy", {31'd0, busy}, 0);
    chk("R9 mid reset no write", {31'd0, dmem_we}, 0);
    chk("R9 mid reset ssp", {16'd0, ssp_out}, 0);
    present(8'hFF, 1, 1, 24'h000300, 16'h4444, 16'h6000);
    wait_done(N_PZ, "R7 after reset length");

    // R8: trigger held high across done restarts only after idle
    @(negedge clk);
    op_valid = 1; op_byte = 8'hFF; page_zero = 0;
    pc_in = 24'h000400; ssp_in = 16'h7000;
    repeat (N_NORM + 2) @(negedge clk);
    op_valid = 0;
    chk("R8 held trigger second trap busy", {31'd0, busy}, 1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule